// File: doc/BRIEF.md
# Debug Address Breakpoint Matcher

This block watches a processor's instruction stream and its data accesses against a small set of programmable debug address slots. Each slot holds an address. A control word gives every slot a kind: execute, write-only watch, read/write watch or inert. It also gives a watch length and two enable bits. In every cycle in which the pipeline presents an evaluation, the block compares the current instruction pointer and the optional data access with each slot. Each slot then either hits or does not.

The hits are recorded in a status word, and an enabled hit raises a one-cycle debug exception request. The status word records hits from disabled slots as well. It is rewritten only when some enabled slot hits, or when the pipeline forces the update. In every other evaluation the status word keeps its previous value. Software programs the slots through a plain register port with a combinational read path.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: After reset every slot address reads 0, the status word reads STAT_RST (default 32'hFFFF0FF0), the control word reads CTRL_RST (default 32'h00000400), and exc_req is 0.
- R2: Register port map: reg_addr 0..NUM_SLOTS-1 selects slot addresses, 4 selects the status word, 5 selects the control word. A write lands at the next clock edge. reg_rdata is a combinational view of the selected register. Every other address reads 0, and writes to it change no register.
- R3: A slot of kind 0 (execute) hits when its address equals ip. The data access does not matter.
- R4: A slot of kind 1 (write watch) hits only when dacc_valid and dacc_write are both 1 and the byte ranges overlap.
- R5: A slot of kind 3 (read/write watch) hits on any valid data access whose byte range overlaps, whether it is a read or a write.
- R6: A slot of kind 2 never hits.
- R7: Control bits 16+4i..17+4i hold the kind of slot i, and bits 18+4i..19+4i hold its length code (0→1, 1→2, 2→8, 3→4 bytes). A watch covers the slot address aligned down to its length, through that many bytes. An access covers dacc_addr through 2^dacc_size bytes. A watch hit needs the two ranges to share at least one byte.
- R8: An evaluation in which an enabled slot hits, or in which force_upd is 1, clears status bits 3:0 and then sets bit i for every slot i that hit, enabled or not. All other status bits are kept. Any other evaluation leaves the status word unchanged.
- R9: exc_req is 1 in the cycle after an evaluation in which at least one enabled slot hit, and 0 otherwise. force_upd and hits from disabled slots never raise it.
- R10: While eval_en is 0, no status change and no exception request occur, whatever ip and the data access are.
- R11: A port write to the status word in the same cycle as a status update wins: the written value is stored. The exception request of that evaluation is unaffected.
- R12: Slot i is enabled when control bit 2i (local) or bit 2i+1 (global) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 3 | Register port address |
| reg_wdata | input | ADDR_W | Register port write data |
| reg_rdata | output | ADDR_W | Register port read data (combinational) |
| eval_en | input | 1 | Evaluate the slots in this cycle |
| ip | input | ADDR_W | Current instruction pointer |
| dacc_valid | input | 1 | A data access is present |
| dacc_addr | input | ADDR_W | Data access start address |
| dacc_size | input | 2 | Data access size code, 2^code bytes |
| dacc_write | input | 1 | Data access is a write |
| force_upd | input | 1 | Rewrite the status word even without an enabled hit |
| exc_req | output | 1 | Debug exception request, one cycle after the evaluation |

## Verification
The bound checker enforces several properties on every cycle. An exception request always follows an evaluation with an enabled hit. An inert slot never hits. A write watch hits only during a write access. The status word stays put when nothing evaluates or writes it. After any firing update, the low status bits equal the hit vector. The byte-range arithmetic needs the bench scenarios to show that it is right, because only concrete addresses exercise it: alignment per length code, partial overlaps at both ends, and adjacent misses. The bench scenarios also cover the priority of a port write over an update, and the register map with its reset values.

// File: rtl/dbg_bkpt_pkg.sv
package dbg_bkpt_pkg;

   localparam int RA_W = 3;

   localparam logic [RA_W-1:0] RA_STAT = 3'd4;
   localparam logic [RA_W-1:0] RA_CTRL = 3'd5;

   localparam int KIND_LSB = 16;
   localparam int LEN_LSB  = 18;
   localparam int FIELD_STRIDE = 4;

   typedef enum logic [1:0] {
      BK_EXEC = 2'd0,
      BK_WR   = 2'd1,
      BK_IO   = 2'd2,
      BK_RW   = 2'd3
   } bk_kind_e;

   // Byte span minus one for a slot length code (1, 2, 8, 4 bytes).
   function automatic logic [3:0] slot_span_m1(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd0;
         2'd1:    return 4'd1;
         2'd2:    return 4'd7;
         default: return 4'd3;
      endcase
   endfunction

   // Byte span minus one for an access size code (1, 2, 4, 8 bytes).
   function automatic logic [3:0] acc_span_m1(input logic [1:0] code);
      return 4'((5'd1 << code) - 5'd1);
   endfunction

endpackage

// File: rtl/dbg_slot_cmp.sv
module dbg_slot_cmp
   import dbg_bkpt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] slot_addr,
   input  bk_kind_e          kind,
   input  logic [1:0]        len_code,
   input  logic [ADDR_W-1:0] ip,
   input  logic              dacc_valid,
   input  logic [ADDR_W-1:0] dacc_addr,
   input  logic [1:0]        dacc_size,
   input  logic              dacc_write,
   output logic              hit
);
   localparam int EXT_W = ADDR_W + 1;

   logic [ADDR_W-1:0] span_mask;
   logic [ADDR_W-1:0] acc_len_m1;
   logic [ADDR_W-1:0] win_lo;
   logic [EXT_W-1:0]  win_hi;
   logic [EXT_W-1:0]  acc_hi;
   logic              overlap;
   logic              exec_match;

   always_comb begin
      span_mask  = ADDR_W'(slot_span_m1(len_code));
      acc_len_m1 = ADDR_W'(acc_span_m1(dacc_size));
      win_lo     = slot_addr & ~span_mask;
      // One extra bit keeps ranges at the top of the space from wrapping.
      win_hi     = {1'b0, win_lo} + {1'b0, span_mask};
      acc_hi     = {1'b0, dacc_addr} + {1'b0, acc_len_m1};
      overlap    = ({1'b0, dacc_addr} <= win_hi) && ({1'b0, win_lo} <= acc_hi);
      exec_match = (slot_addr == ip);
   end

   always_comb begin
      unique case (kind)
         BK_EXEC: hit = exec_match;
         BK_WR:   hit = dacc_valid && dacc_write && overlap;
         BK_RW:   hit = dacc_valid && overlap;
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/dbg_bkpt_regs.sv
module dbg_bkpt_regs
   import dbg_bkpt_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                NUM_SLOTS = 4,
   parameter logic [ADDR_W-1:0] STAT_RST  = ADDR_W'(32'hFFFF0FF0),
   parameter logic [ADDR_W-1:0] CTRL_RST  = ADDR_W'(32'h00000400)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [RA_W-1:0]                   reg_addr,
   input  logic [ADDR_W-1:0]                 reg_wdata,
   output logic [ADDR_W-1:0]                 reg_rdata,
   input  logic                              upd_fire,
   input  logic [NUM_SLOTS-1:0]              hit_vec,
   output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_q,
   output logic [ADDR_W-1:0]                 ctrl_q,
   output logic [ADDR_W-1:0]                 status_q
);
   localparam logic [ADDR_W-1:0] LOW_CLR = ADDR_W'(4'hF);

   logic [ADDR_W-1:0] status_upd;

   always_comb
      status_upd = (status_q & ~LOW_CLR) | ADDR_W'(hit_vec);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q   <= '0;
         ctrl_q   <= CTRL_RST;
         status_q <= STAT_RST;
      end else begin
         if (upd_fire)
            status_q <= status_upd;
         // Port writes come last so they win over an update.
         if (reg_we && reg_addr == RA_STAT)
            status_q <= reg_wdata;
         if (reg_we && reg_addr == RA_CTRL)
            ctrl_q <= reg_wdata;
         for (int i = 0; i < NUM_SLOTS; i++)
            if (reg_we && reg_addr == RA_W'(i))
               slot_q[i] <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == RA_STAT)
         reg_rdata = status_q;
      else if (reg_addr == RA_CTRL)
         reg_rdata = ctrl_q;
      else
         for (int i = 0; i < NUM_SLOTS; i++)
            if (reg_addr == RA_W'(i))
               reg_rdata = slot_q[i];
   end

endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
   import dbg_bkpt_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                NUM_SLOTS = 4,
   parameter logic [ADDR_W-1:0] STAT_RST  = ADDR_W'(32'hFFFF0FF0),
   parameter logic [ADDR_W-1:0] CTRL_RST  = ADDR_W'(32'h00000400)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              eval_en,
   input  logic [ADDR_W-1:0] ip,
   input  logic              dacc_valid,
   input  logic [ADDR_W-1:0] dacc_addr,
   input  logic [1:0]        dacc_size,
   input  logic              dacc_write,
   input  logic              force_upd,
   output logic              exc_req
);
   if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
      $error("dbg_bkpt_unit: NUM_SLOTS must lie in 1..4");
   end
   if (ADDR_W < 32 || ADDR_W > 64) begin : g_bad_width
      $error("dbg_bkpt_unit: ADDR_W must lie in 32..64");
   end

   logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_q;
   logic [ADDR_W-1:0]                ctrl_q;
   logic [ADDR_W-1:0]                status_q;
   logic [NUM_SLOTS-1:0]             hit_vec;
   logic [NUM_SLOTS-1:0]             en_vec;
   logic                             en_hit;
   logic                             upd_fire;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      localparam int KB = KIND_LSB + FIELD_STRIDE * g;
      localparam int LB = LEN_LSB  + FIELD_STRIDE * g;

      assign en_vec[g] = |ctrl_q[2*g+1 : 2*g];

      dbg_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .slot_addr  (slot_q[g]),
         .kind       (bk_kind_e'(ctrl_q[KB+1:KB])),
         .len_code   (ctrl_q[LB+1:LB]),
         .ip         (ip),
         .dacc_valid (dacc_valid),
         .dacc_addr  (dacc_addr),
         .dacc_size  (dacc_size),
         .dacc_write (dacc_write),
         .hit        (hit_vec[g])
      );
   end

   assign en_hit   = |(hit_vec & en_vec);
   assign upd_fire = eval_en && (en_hit || force_upd);

   dbg_bkpt_regs #(
      .ADDR_W    (ADDR_W),
      .NUM_SLOTS (NUM_SLOTS),
      .STAT_RST  (STAT_RST),
      .CTRL_RST  (CTRL_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .upd_fire  (upd_fire),
      .hit_vec   (hit_vec),
      .slot_q    (slot_q),
      .ctrl_q    (ctrl_q),
      .status_q  (status_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) exc_req <= 1'b0;
      else        exc_req <= eval_en && en_hit;
   end

endmodule

// File: rtl/dbg_bkpt_chk.sv
module dbg_bkpt_chk #(
   parameter int ADDR_W    = 32,
   parameter int NUM_SLOTS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 eval_en,
   input logic                 force_upd,
   input logic                 reg_we,
   input logic [2:0]           reg_addr,
   input logic                 dacc_valid,
   input logic                 dacc_write,
   input logic                 exc_req,
   input logic [NUM_SLOTS-1:0] hit_vec,
   input logic [NUM_SLOTS-1:0] en_vec,
   input logic [ADDR_W-1:0]    ctrl_q,
   input logic [ADDR_W-1:0]    status_q
);
   logic stat_wr;
   assign stat_wr = reg_we && (reg_addr == 3'd4);

   p_exc_after_eval_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> $past(eval_en) && ($past(hit_vec & en_vec) != '0));

   p_status_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!eval_en && !stat_wr) |=> $stable(status_q));

   p_status_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && ((hit_vec & en_vec) != '0 || force_upd) && !stat_wr)
      |=> status_q[NUM_SLOTS-1:0] == $past(hit_vec));

   p_no_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_en && (hit_vec & en_vec) == '0 && !force_upd && !stat_wr)
      |=> $stable(status_q));

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
      p_io_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_q[17+4*g -: 2] == 2'd2) |-> !hit_vec[g]);
      p_wr_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_q[17+4*g -: 2] == 2'd1 && hit_vec[g]) |-> (dacc_valid && dacc_write));
   end

endmodule

bind dbg_bkpt_unit dbg_bkpt_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eval_en    (eval_en),
   .force_upd  (force_upd),
   .reg_we     (reg_we),
   .reg_addr   (reg_addr),
   .dacc_valid (dacc_valid),
   .dacc_write (dacc_write),
   .exc_req    (exc_req),
   .hit_vec    (hit_vec),
   .en_vec     (en_vec),
   .ctrl_q     (ctrl_q),
   .status_q   (status_q)
);

// File: tb/dbg_bkpt_unit_tb.sv
module dbg_bkpt_unit_tb;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic         eval_en = 1'b0;
   logic [W-1:0] ip = '0;
   logic         dacc_valid = 1'b0;
   logic [W-1:0] dacc_addr = '0;
   logic [1:0]   dacc_size = '0;
   logic         dacc_write = 1'b0;
   logic         force_upd = 1'b0;
   logic         exc_req;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dbg_bkpt_unit u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eval_en(eval_en),
      .ip(ip), .dacc_valid(dacc_valid), .dacc_addr(dacc_addr),
      .dacc_size(dacc_size), .dacc_write(dacc_write),
      .force_upd(force_upd), .exc_req(exc_req)
   );

   // Bench model of the programmable state
   logic [W-1:0] m_addr [4];
   logic [W-1:0] m_ctrl;
   logic [W-1:0] m_stat;

   typedef struct {
      int           due;
      logic         exc;
      logic [W-1:0] stat;
      string        tag;
   } exp_t;
   exp_t exp_q[$];

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Monitor: compares results one cycle after each evaluation
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         check({e.tag, " exc"}, W'(exc_req), W'(e.exc));
         check({e.tag, " status"}, reg_rdata, e.stat);
      end
   end

   function automatic bit m_hit(input int i, input logic [W-1:0] p, input bit dv,
                                input logic [W-1:0] da, input int ds, input bit dw);
      int kind, lc;
      longint unsigned len, base, alen, a;
      bit ovl;
      kind = int'((m_ctrl >> (16 + 4*i)) & 3);
      lc   = int'((m_ctrl >> (18 + 4*i)) & 3);
      len  = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 2) ? 8 : 4;
      base = longint'(m_addr[i]) - (longint'(m_addr[i]) % len);
      alen = longint'(1) << ds;
      a    = longint'(da);
      ovl  = (a <= base + len - 1) && (base <= a + alen - 1);
      case (kind)
         0: return p == m_addr[i];
         1: return dv && dw && ovl;
         3: return dv && ovl;
         default: return 1'b0;
      endcase
   endfunction

   task automatic reg_wr(input int a, input logic [W-1:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
      if (a == 4) m_stat = d;
      else if (a == 5) m_ctrl = d;
      else if (a < 4) m_addr[a] = d;
   endtask

   task automatic reg_chk(input int a, input logic [W-1:0] exp, input string tag);
      @(negedge clk);
      reg_addr = 3'(a);
      #1 check(tag, reg_rdata, exp);
   endtask

   task automatic set_slot(input int i, input int kind, input int lc, input bit el, input bit eg);
      logic [W-1:0] c;
      c = m_ctrl;
      c[2*i]     = el;
      c[2*i+1]   = eg;
      c[16+4*i +: 2] = 2'(kind);
      c[18+4*i +: 2] = 2'(lc);
      reg_wr(5, c);
   endtask

   // Driver: one evaluation cycle, expected result pushed to the scoreboard
   task automatic do_eval(input logic [W-1:0] p, input bit dv, input logic [W-1:0] da,
                          input int ds, input bit dw, input bit frc, input bit ev,
                          input bit swr, input logic [W-1:0] swd, input string tag);
      logic [3:0] hits;
      bit enh;
      exp_t e;
      hits = '0; enh = 1'b0;
      for (int i = 0; i < 4; i++) begin
         hits[i] = m_hit(i, p, dv, da, ds, dw);
         if (hits[i] && ((m_ctrl >> (2*i)) & 3) != 0) enh = 1'b1;
      end
      if (ev && (enh || frc)) m_stat = (m_stat & ~32'hF) | W'(hits);
      if (swr) m_stat = swd;
      @(negedge clk);
      eval_en = ev; ip = p; dacc_valid = dv; dacc_addr = da;
      dacc_size = 2'(ds); dacc_write = dw; force_upd = frc;
      reg_addr = 3'd4; reg_we = swr; reg_wdata = swd;
      e.due = cyc + 1; e.exc = ev && enh; e.stat = m_stat; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      eval_en = 1'b0; dacc_valid = 1'b0; force_upd = 1'b0; reg_we = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 4; i++) m_addr[i] = '0;
      m_ctrl = 32'h00000400;
      m_stat = 32'hFFFF0FF0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 4; i++) reg_chk(i, 32'h0, "R1 slot addr reset");
      reg_chk(4, 32'hFFFF0FF0, "R1 status reset");
      reg_chk(5, 32'h00000400, "R1 control reset");
      check("R1 exc reset", W'(exc_req), 0);

      // R2 register map and unmapped addresses
      reg_wr(0, 32'h1000); reg_wr(1, 32'h2002); reg_wr(2, 32'h3005); reg_wr(3, 32'h4000);
      reg_chk(1, 32'h2002, "R2 slot1 readback");
      reg_chk(3, 32'h4000, "R2 slot3 readback");
      reg_wr(7, 32'hDEADBEEF);
      m_addr[3] = 32'h4000;
      reg_chk(7, 32'h0, "R2 unmapped reads zero");
      reg_chk(0, 32'h1000, "R2 unmapped write ignored slot0");
      reg_chk(5, 32'h00000400, "R2 unmapped write ignored ctrl");
      reg_chk(4, 32'hFFFF0FF0, "R2 unmapped write ignored status");

      // R3 execute slot, local enable (R12)
      set_slot(0, 0, 0, 1, 0);
      do_eval(32'h1000, 0, 0, 0, 0, 0, 1, 0, 0, "R3 R12 exec hit local");
      do_eval(32'h1004, 0, 0, 0, 0, 0, 1, 0, 0, "R3 exec miss keeps status");

      // R4 R7 write watch, length code 3 (4 bytes) at 0x2000..0x2003
      set_slot(1, 1, 3, 1, 0);
      do_eval(32'h9000, 1, 32'h2001, 0, 0, 0, 1, 0, 0, "R4 read ignored by write watch");
      do_eval(32'h9000, 1, 32'h2003, 0, 1, 0, 1, 0, 0, "R4 R7 write at window end");
      do_eval(32'h9000, 1, 32'h1FFE, 1, 1, 0, 1, 0, 0, "R7 adjacent below misses");
      do_eval(32'h9000, 1, 32'h1FFE, 2, 1, 0, 1, 0, 0, "R7 partial overlap from below");

      // R5 R7 read/write watch, length code 2 (8 bytes) at 0x3000..0x3007
      set_slot(2, 3, 2, 0, 1);
      do_eval(32'h9000, 1, 32'h3007, 0, 0, 0, 1, 0, 0, "R5 R12 read hit global enable");
      do_eval(32'h9000, 1, 32'h3008, 3, 1, 0, 1, 0, 0, "R5 R7 just above window misses");

      // R7 length code 1 (2 bytes): slot2 at 0x3005 -> 0x3004..0x3005
      set_slot(2, 3, 1, 0, 1);
      do_eval(32'h9000, 1, 32'h3006, 0, 1, 0, 1, 0, 0, "R7 two-byte window miss");
      do_eval(32'h9000, 1, 32'h3004, 0, 0, 0, 1, 0, 0, "R7 two-byte window hit");

      // R6 inert kind never hits
      set_slot(3, 2, 0, 1, 1);
      do_eval(32'h4000, 1, 32'h4000, 0, 1, 0, 1, 0, 0, "R6 kind 2 no hit");

      // R8 R9 disabled slot hit alone
      set_slot(0, 0, 0, 0, 0);
      do_eval(32'h1000, 0, 0, 0, 0, 0, 1, 0, 0, "R8 disabled hit alone no update");
      do_eval(32'h1000, 0, 0, 0, 0, 1, 1, 0, 0, "R8 R9 force records disabled hit");
      do_eval(32'h1000, 1, 32'h3005, 0, 1, 0, 1, 0, 0, "R8 enabled plus disabled hits");

      // R10 no evaluation
      do_eval(32'h1000, 1, 32'h3004, 0, 1, 1, 0, 0, 0, "R10 eval low no effect");

      // R11 port write wins over update
      do_eval(32'h1000, 1, 32'h3004, 0, 1, 0, 1, 1, 32'h12345670, "R11 port write wins");

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule